// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 64-bit operand address from up to four pieces: a base register value, an index register value shifted left by a 2-bit scale code, and a signed 32-bit displacement. Either register operand may be left out, and a reserved index register number (the stack pointer, number 4) always reads as "no index". The datapath is one adder stage followed by one output register.

An operation is presented with a one-cycle `in_valid` strobe. One clock later the block raises `out_valid` for one cycle and presents the computed value on `addr_out`. Two strobes say where the value goes. `mem_req` means the value is an address for a load or a store. `reg_wr` means the operation was in load-effective-address mode, so the value is a result for a destination register and no memory request is made. The block has no status-flag outputs, so an address calculation can never disturb condition codes. Reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `ea_gen`

## Requirements
- R1: `addr_out` equals base + (index << scale) + sign-extended displacement, where each term is taken as zero when it is absent.
- R2: `scale_code` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively.
- R3: When `index_present` is 0, the index term is zero whatever `index_val` and `scale_code` hold.
- R4: When `base_present` is 0, the base term is zero whatever `base_val` holds. For example, index 0xf000, scale code 1 and displacement 0x80 give 0x1e080.
- R5: When `index_regnum` equals 4, the index term is zero even if `index_present` is 1.
- R6: `disp` is a signed 32-bit value sign-extended to 64 bits. A displacement of 0 adds nothing.
- R7: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1 and reset was released, and 0 at all other times.
- R8: While `out_valid` is 1, `mem_req` is 1 and `reg_wr` is 0 if `lea_mode` was 0, and `reg_wr` is 1 and `mem_req` is 0 if `lea_mode` was 1. Both are 0 while `out_valid` is 0.
- R9: While `rst_n` is 0, `out_valid`, `mem_req` and `reg_wr` are 0 and `addr_out` is 0. Inputs are ignored until two clock edges after `rst_n` rises.
- R10: `addr_out` holds its last value in every cycle that follows a cycle without `in_valid`.
- R11: All sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; inputs are captured when it is high |
| lea_mode | input | 1 | 1 = write the result to a register, 0 = memory access |
| base_present | input | 1 | Base operand is used |
| base_val | input | 64 | Base register value |
| index_present | input | 1 | Index operand is used |
| index_regnum | input | 4 | Index register number (4 is reserved) |
| index_val | input | 64 | Index register value |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp | input | 32 | Signed displacement |
| out_valid | output | 1 | Result valid pulse |
| mem_req | output | 1 | Result is a memory address |
| reg_wr | output | 1 | Result goes to the destination register |
| addr_out | output | 64 | Computed address or result |

## Verification
The bound checker watches the handshake on every cycle. It checks that `out_valid` follows `in_valid` by exactly one cycle, that exactly one of `mem_req` and `reg_wr` accompanies each result and that it matches the mode, and that the result holds when no operation was accepted. It also checks the arithmetic for the cases where the index term drops out: index absent, reserved index number, or both registers absent. The scale shifts, the wrap-around at 2^64, asynchronous reset in the middle of a run and the release delay are shown only by the bench's scenarios with known answers.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_MEM  = 2'd1,
    DEST_REG  = 2'd2
  } dest_kind_e;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) chain_q <= '0;
        else           chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/ea_index_term.sv
module ea_index_term #(
  parameter int ADDR_W   = 64,
  parameter int REGNUM_W = 4,
  parameter int SCALE_W  = 2,
  parameter int RSV_IDX  = 4
) (
  input  logic                index_present,
  input  logic [REGNUM_W-1:0] index_regnum,
  input  logic [ADDR_W-1:0]   index_val,
  input  logic [SCALE_W-1:0]  scale_code,
  output logic [ADDR_W-1:0]   index_term
);
  localparam int NUM_SCALES = 1 << SCALE_W;

  logic                           idx_used;
  logic [NUM_SCALES-1:0][ADDR_W-1:0] shifted;

  assign idx_used = index_present && (index_regnum != REGNUM_W'(RSV_IDX));

  genvar s;
  generate
    for (s = 0; s < NUM_SCALES; s++) begin : g_shift
      assign shifted[s] = index_val << s;
    end
  endgenerate

  always_comb begin
    index_term = '0;
    if (idx_used) index_term = shifted[scale_code];
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32
) (
  input  logic              base_present,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_term,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] sum
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_term;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_noext
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  assign base_term = base_present ? base_val : '0;
  assign sum       = base_term + index_term + disp_ext;
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int ADDR_W    = 64,
  parameter int DISP_W    = 32,
  parameter int REGNUM_W  = 4,
  parameter int SCALE_W   = 2,
  parameter int RSV_IDX   = 4,
  parameter int RST_STAGE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                lea_mode,
  input  logic                base_present,
  input  logic [ADDR_W-1:0]   base_val,
  input  logic                index_present,
  input  logic [REGNUM_W-1:0] index_regnum,
  input  logic [ADDR_W-1:0]   index_val,
  input  logic [SCALE_W-1:0]  scale_code,
  input  logic [DISP_W-1:0]   disp,
  output logic                out_valid,
  output logic                mem_req,
  output logic                reg_wr,
  output logic [ADDR_W-1:0]   addr_out
);
  import ea_pkg::*;

  logic              rst_ok;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] addr_d, addr_q;
  dest_kind_e        dest_d, dest_q;
  logic              addr_en;

  ea_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_ok)
  );

  ea_index_term #(
    .ADDR_W(ADDR_W), .REGNUM_W(REGNUM_W), .SCALE_W(SCALE_W), .RSV_IDX(RSV_IDX)
  ) u_idx (
    .index_present(index_present),
    .index_regnum (index_regnum),
    .index_val    (index_val),
    .scale_code   (scale_code),
    .index_term   (index_term)
  );

  ea_sum #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sum (
    .base_present(base_present),
    .base_val    (base_val),
    .index_term  (index_term),
    .disp        (disp),
    .sum         (sum)
  );

  // next-state
  always_comb begin
    addr_en = in_valid;
    addr_d  = addr_q;
    dest_d  = DEST_NONE;
    if (in_valid) begin
      addr_d = sum;
      dest_d = lea_mode ? DEST_REG : DEST_MEM;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      addr_q <= '0;
      dest_q <= DEST_NONE;
    end else begin
      dest_q <= dest_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign out_valid = (dest_q != DEST_NONE);
  assign mem_req   = (dest_q == DEST_MEM);
  assign reg_wr    = (dest_q == DEST_REG);
  assign addr_out  = addr_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W   = 64,
  parameter int DISP_W   = 32,
  parameter int REGNUM_W = 4,
  parameter int RSV_IDX  = 4
) (
  input logic                clk,
  input logic                rst_ok,
  input logic                in_valid,
  input logic                lea_mode,
  input logic                base_present,
  input logic [ADDR_W-1:0]   base_val,
  input logic                index_present,
  input logic [REGNUM_W-1:0] index_regnum,
  input logic [DISP_W-1:0]   disp,
  input logic                out_valid,
  input logic                mem_req,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   addr_out
);
  logic [ADDR_W-1:0] dx;
  assign dx = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid); // R7
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid |-> ($countones({mem_req, reg_wr}) == 1)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !out_valid |-> !mem_req && !reg_wr); // R8
  AST_LEA_DEST: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && lea_mode |=> reg_wr && !mem_req); // R8
  AST_MEM_DEST: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && !lea_mode |=> mem_req && !reg_wr); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(addr_out)); // R10
  AST_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && base_present && !index_present
      |=> addr_out == $past(base_val + dx)); // R3
  AST_RSV_INDEX: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && base_present && index_present && (index_regnum == REGNUM_W'(RSV_IDX))
      |=> addr_out == $past(base_val + dx)); // R5
  AST_DISP_ONLY: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && !base_present && !index_present |=> addr_out == $past(dx)); // R6
endmodule

bind ea_gen ea_gen_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .REGNUM_W(REGNUM_W), .RSV_IDX(RSV_IDX)
) u_chk (.*);

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, lea_mode, base_present, index_present;
  logic [63:0] base_val, index_val;
  logic [3:0]  index_regnum;
  logic [1:0]  scale_code;
  logic [31:0] disp;
  logic        out_valid, mem_req, reg_wr;
  logic [63:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ea_gen dut (.*);

  // vector table: base, index, disp, scale, base_present, index_present, regnum, lea, expected
  localparam logic [63:0] T_BASE [NV] = '{64'hf000, 64'hf000, 64'hf000, 64'h0, 64'hf000, 64'h1000,
    64'h10, 64'hffff_ffff_ffff_ffff, 64'h5, 64'h7, 64'h0, 64'h1234};
  localparam logic [63:0] T_IDX  [NV] = '{64'h100, 64'h100, 64'h100, 64'hf000, 64'h100, 64'h0,
    64'h3, 64'h1, 64'h7, 64'h7, 64'h0, 64'h55};
  localparam logic [31:0] T_DISP [NV] = '{32'h8, 32'h0, 32'h0, 32'h80, 32'h0, 32'hffff_fff0,
    32'h0, 32'h2, 32'h0, 32'h0, 32'h7fff_ffff, 32'h8000_0000};
  localparam logic [1:0]  T_SC   [NV] = '{2'd0, 2'd0, 2'd2, 2'd1, 2'd3, 2'd0,
    2'd3, 2'd0, 2'd2, 2'd1, 2'd0, 2'd3};
  localparam logic        T_BP   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic        T_IP   [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [3:0]  T_RN   [NV] = '{4'd1, 4'd1, 4'd1, 4'd2, 4'd4, 4'd1,
    4'd1, 4'd3, 4'd1, 4'd7, 4'd0, 4'd5};
  localparam logic        T_LEA  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [63:0] T_EXP  [NV] = '{64'hf008, 64'hf100, 64'hf400, 64'h1e080, 64'hf000, 64'hff0,
    64'h28, 64'h2, 64'h5, 64'h15, 64'h7fff_ffff, 64'hffff_ffff_8000_0000};
  localparam string       T_REQ  [NV] = '{"R1", "R1", "R2", "R4", "R5", "R6",
    "R8", "R11", "R3", "R2", "R6", "R6"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    in_valid      = 1'b1;
    base_val      = T_BASE[i];
    index_val     = T_IDX[i];
    disp          = T_DISP[i];
    scale_code    = T_SC[i];
    base_present  = T_BP[i];
    index_present = T_IP[i];
    index_regnum  = T_RN[i];
    lea_mode      = T_LEA[i];
  endtask

  task automatic idle();
    in_valid      = 1'b0;
    base_val      = 64'hdead_beef_0000_1111;
    index_val     = 64'h5555;
    disp          = 32'h44;
    scale_code    = 2'd1;
    base_present  = 1'b1;
    index_present = 1'b1;
    index_regnum  = 4'd2;
    lea_mode      = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R7: watchdog expired, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] last;
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", {63'd0, out_valid}, 64'd0);
    chk("R9", {62'd0, mem_req, reg_wr}, 64'd0);
    chk("R9", addr_out, 64'd0);
    rst_n = 1'b1;
    // R9: strobe during release window is ignored
    drive(0);
    @(negedge clk);
    idle();
    chk("R9", {63'd0, out_valid}, 64'd0);
    repeat (3) @(negedge clk);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      drive(i);
      @(negedge clk);
      idle();
      chk(T_REQ[i], addr_out, T_EXP[i]);
      chk("R7", {63'd0, out_valid}, 64'd1);
      chk("R8", {62'd0, mem_req, reg_wr}, T_LEA[i] ? 64'd1 : 64'd2);
      @(negedge clk);
      chk("R7", {63'd0, out_valid}, 64'd0);
    end

    // R10: hold with no strobe for several cycles
    last = addr_out;
    repeat (3) @(negedge clk);
    chk("R10", addr_out, last);
    chk("R8", {62'd0, mem_req, reg_wr}, 64'd0);

    // back-to-back operations, R7/R8
    drive(6);
    @(negedge clk);
    drive(2);
    chk("R8", {62'd0, mem_req, reg_wr}, 64'd1);
    chk("R1", addr_out, 64'h28);
    @(negedge clk);
    idle();
    chk("R7", {63'd0, out_valid}, 64'd1);
    chk("R2", addr_out, 64'hf400);

    // R3: garbage index ignored when absent, all scale codes
    for (int s = 0; s < 4; s++) begin
      drive(8);
      scale_code = 2'(s);
      index_val  = 64'hffff_0000_ffff_0000;
      @(negedge clk);
      idle();
      chk("R3", addr_out, 64'h5);
    end

    // R5: reserved index with every scale
    for (int s = 0; s < 4; s++) begin
      drive(4);
      scale_code = 2'(s);
      @(negedge clk);
      idle();
      chk("R5", addr_out, 64'hf000);
    end

    // R9: asynchronous reset mid-run
    drive(1);
    @(negedge clk);
    idle();
    #1 rst_n = 1'b0;
    #1;
    chk("R9", {63'd0, out_valid}, 64'd0);
    chk("R9", addr_out, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(3);
    @(negedge clk);
    idle();
    chk("R4", addr_out, 64'h1e080);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule